// File: doc/BRIEF.md
# Triplicated Voted Program Counter

This block keeps three copies of a processor program counter. Each copy sits in its own clock domain with its own clock and its own reset. A bitwise two-of-three majority of the copies forms one voted PC, and that single value drives the next-address logic of all three copies. A copy therefore never builds on its own register contents. A copy disturbed by a glitched, doubled, stalled or reset clock is outvoted while the other two agree. On its next good update it loads the same value as the others, and it does so without any resynchronisation command.

Each copy runs a two-state controller. In `ST_IDLE`, entered by reset, the copy presents the reset vector. The transition IDLE→RUN fires on the first clock edge after reset is released, and the PC is not changed on that edge. In `ST_RUN`, the copy loops RUN→RUN on every later edge. On each such edge it loads either the voted PC plus four or, when the branch select is high, the branch target with its two low bits cleared. A per-copy flag reports whenever that copy differs from the voted value.

Top module: `tvpc_top`

## Requirements
- R1: While a copy's reset is high, its vote is 0x00000000 and its controller is in ST_IDLE. With all three resets high, the voted PC is 0x00000000 and all mismatch flags are 0.
- R2: On the first rising edge of its clock after its reset falls, a copy moves from ST_IDLE to ST_RUN and keeps the value 0x00000000.
- R3: In ST_RUN with the branch select low, each rising edge of a copy's clock loads that copy with the voted PC (as it stood before the edge) plus 4.
- R4: In ST_RUN with the branch select high, each rising edge loads that copy with the branch target with bits [1:0] forced to 0. For example, a target of 0x00000203 yields 0x00000200.
- R5: The voted PC is, bit by bit, the value held by at least two of the three copies.
- R6: Mismatch bit i (bit 0 for copy 0, bit 1 for copy 1, bit 2 for copy 2) is 1 exactly when copy i differs from the voted PC. Whenever two copies agree, at most one bit is set.
- R7: If one clock runs at twice the rate of the other two, the voted PC still follows the sequence set by the two agreeing copies. The fast copy rejoins them on their next common edge.
- R8: If one clock runs at a quarter of the rate of the other two, that copy is outvoted while it lags. It agrees with the others again after its next edge.
- R9: Every copy's value always has bits [1:0] equal to 0.
- R10: If one copy is held in reset while the others run, the voted PC is unaffected. Within two edges of that copy's clock after release, the copy matches the others again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0_i | input | 1 | Clock of copy 0 |
| clk1_i | input | 1 | Clock of copy 1 |
| clk2_i | input | 1 | Clock of copy 2 |
| rst0_i | input | 1 | Asynchronous active-high reset of copy 0 |
| rst1_i | input | 1 | Asynchronous active-high reset of copy 1 |
| rst2_i | input | 1 | Asynchronous active-high reset of copy 2 |
| take_i | input | 1 | Branch select: load the target instead of voted PC + 4 |
| target_i | input | 32 | Branch or jump target address |
| voted_o | output | 32 | Majority PC for the downstream fetch logic |
| vote0_o | output | 32 | Current value of copy 0 |
| vote1_o | output | 32 | Current value of copy 1 |
| vote2_o | output | 32 | Current value of copy 2 |
| mismatch_o | output | 3 | Per-copy disagreement with the voted PC |

## Verification
A corrupted copy shows at once on its own vote output and its mismatch bit, but never on the voted PC while the other two agree. If the corruption is in the shared next-address path, every copy loads the wrong value on the same edge, so the voted PC is wrong one edge after the cause and stays wrong. The bench compares all five outputs with a behavioural model after every 5 ns step. This covers a doubled clock, a quartered clock and a single held reset. The fault therefore shows within one edge of the affected clock.

// File: rtl/tvpc_pkg.sv
`timescale 1ns/1ps
package tvpc_pkg;

    // Number of redundant copies; two-of-three voting needs exactly three.
    localparam int unsigned COPIES = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,   // presenting the reset vector
        ST_RUN  = 1'b1    // advancing from the voted value
    } copy_state_t;

endpackage

// File: rtl/tvpc_replica.sv
`timescale 1ns/1ps
module tvpc_replica
    import tvpc_pkg::*;
#(
    parameter int unsigned PC_W       = 32,
    parameter int unsigned ALIGN_BITS = 2,
    parameter int unsigned STEP       = 4,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [PC_W-1:0] voted_i,
    input  logic [PC_W-1:0] target_i,
    input  logic            take_i,
    output logic [PC_W-1:0] pc_o
);

    localparam logic [PC_W-1:0] STEP_V     = PC_W'(STEP);
    localparam logic [PC_W-1:0] ALIGN_MASK = PC_W'((64'd1 << ALIGN_BITS) - 64'd1);

    copy_state_t     state_q, state_d;
    logic [PC_W-1:0] pc_q, pc_d;

    // Next state and next value: always built from the shared vote.
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_RUN;
            end
            ST_RUN: begin
                if (take_i) begin
                    pc_d = target_i & ~ALIGN_MASK;
                end else begin
                    pc_d = voted_i + STEP_V;
                end
            end
        endcase
    end

    // State and value registers in this copy's own clock domain.
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            pc_q    <= RESET_PC;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    assign pc_o = pc_q;

    AST_IDLE_VECTOR: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE) |-> (pc_q == RESET_PC));  // R2

    AST_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (rst_i)
        ((pc_q & ALIGN_MASK) == '0));  // R9

endmodule

// File: rtl/tvpc_voter.sv
`timescale 1ns/1ps
module tvpc_voter
    import tvpc_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic [COPIES-1:0][PC_W-1:0] votes_i,
    output logic [PC_W-1:0]             voted_o,
    output logic [COPIES-1:0]           differs_o
);

    // Bitwise two-of-three majority.
    for (genvar b = 0; b < PC_W; b++) begin : g_bit
        assign voted_o[b] = (votes_i[0][b] & votes_i[1][b])
                          | (votes_i[0][b] & votes_i[2][b])
                          | (votes_i[1][b] & votes_i[2][b]);
    end

    // Disagreement of each copy with the vote.
    for (genvar c = 0; c < COPIES; c++) begin : g_flag
        assign differs_o[c] = (votes_i[c] != voted_o);
    end

endmodule

// File: rtl/tvpc_top.sv
`timescale 1ns/1ps
module tvpc_top
    import tvpc_pkg::*;
#(
    parameter int unsigned PC_W       = 32,
    parameter int unsigned ALIGN_BITS = 2,
    parameter int unsigned STEP       = 4
) (
    input  logic            clk0_i,
    input  logic            clk1_i,
    input  logic            clk2_i,
    input  logic            rst0_i,
    input  logic            rst1_i,
    input  logic            rst2_i,
    input  logic            take_i,
    input  logic [PC_W-1:0] target_i,
    output logic [PC_W-1:0] voted_o,
    output logic [PC_W-1:0] vote0_o,
    output logic [PC_W-1:0] vote1_o,
    output logic [PC_W-1:0] vote2_o,
    output logic [2:0]      mismatch_o
);

    logic [COPIES-1:0]           clk_v;
    logic [COPIES-1:0]           rst_v;
    logic [COPIES-1:0][PC_W-1:0] votes;
    logic [PC_W-1:0]             voted;
    logic [COPIES-1:0]           differs;

    assign clk_v = {clk2_i, clk1_i, clk0_i};
    assign rst_v = {rst2_i, rst1_i, rst0_i};

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        tvpc_replica #(
            .PC_W       (PC_W),
            .ALIGN_BITS (ALIGN_BITS),
            .STEP       (STEP),
            .RESET_PC   ('0)
        ) u_copy (
            .clk_i    (clk_v[c]),
            .rst_i    (rst_v[c]),
            .voted_i  (voted),
            .target_i (target_i),
            .take_i   (take_i),
            .pc_o     (votes[c])
        );
    end

    tvpc_voter #(
        .PC_W (PC_W)
    ) u_voter (
        .votes_i   (votes),
        .voted_o   (voted),
        .differs_o (differs)
    );

    assign voted_o    = voted;
    assign vote0_o    = votes[0];
    assign vote1_o    = votes[1];
    assign vote2_o    = votes[2];
    assign mismatch_o = differs;

    AST_PAIR_WINS: assert property (@(posedge clk1_i) disable iff (rst1_i)
        (vote0_o == vote2_o) |-> (voted_o == vote0_o));  // R5

    AST_SINGLE_DISSENT: assert property (@(posedge clk1_i) disable iff (rst1_i)
        ((vote0_o == vote1_o) || (vote1_o == vote2_o) || (vote0_o == vote2_o))
            |-> ($countones(mismatch_o) <= 1));  // R6

endmodule

// File: tb/tb_tvpc_top.sv
`timescale 1ns/1ps
module tb_tvpc_top;

    logic        clk0, clk1, clk2;
    logic        rst0, rst1, rst2;
    logic        take;
    logic [31:0] target;
    logic [31:0] voted, v0, v1, v2;
    logic [2:0]  mism;

    tvpc_top dut (
        .clk0_i (clk0), .clk1_i (clk1), .clk2_i (clk2),
        .rst0_i (rst0), .rst1_i (rst1), .rst2_i (rst2),
        .take_i (take), .target_i (target),
        .voted_o (voted), .vote0_o (v0), .vote1_o (v1), .vote2_o (v2),
        .mismatch_o (mism)
    );

    int          checks = 0;
    int          errors = 0;
    int          t = 0;
    int          div [3];
    int          req_div [3];
    logic [31:0] m [3];
    bit          idle [3];
    string       tag = "R1";
    event        checked;

    function automatic logic [31:0] maj(logic [31:0] a, logic [31:0] b, logic [31:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at t=%0d", tag, what, act, exp, t);
        end
    endtask

    task automatic wait_ticks(int n);
        repeat (n) @(checked);
    endtask

    // Base tick of 5 ns: clocks toggle only on ticks; a 50 MHz clock
    // toggles every second tick. Reference model updates at the same ticks.
    initial begin
        logic [31:0] mv;
        logic [31:0] mv2;
        logic        nc [3];
        logic        cur [3];
        logic        rs [3];
        clk0 = 1'b0; clk1 = 1'b0; clk2 = 1'b0;
        for (int i = 0; i < 3; i++) begin
            m[i] = 32'h0; idle[i] = 1'b1; div[i] = 2;
        end
        forever begin
            #3;
            t++;
            if (t % 16 == 0) begin
                for (int i = 0; i < 3; i++) div[i] = req_div[i];
            end
            cur[0] = clk0; cur[1] = clk1; cur[2] = clk2;
            rs[0] = rst0; rs[1] = rst1; rs[2] = rst2;
            mv = maj(m[0], m[1], m[2]);
            for (int i = 0; i < 3; i++) begin
                nc[i] = ((t / div[i]) % 2) == 0;
                if (rs[i]) begin
                    m[i] = 32'h0;
                    idle[i] = 1'b1;
                end else if (nc[i] && !cur[i]) begin
                    if (idle[i]) idle[i] = 1'b0;
                    else if (take) m[i] = target & 32'hFFFF_FFFC;
                    else m[i] = mv + 32'd4;
                end
            end
            clk0 = nc[0]; clk1 = nc[1]; clk2 = nc[2];
            #2;
            mv2 = maj(m[0], m[1], m[2]);
            cmp("voted", voted, mv2);
            cmp("vote0", v0, m[0]);
            cmp("vote1", v1, m[1]);
            cmp("vote2", v2, m[2]);
            cmp("mismatch", {29'd0, mism},
                {29'd0, m[2] != mv2, m[1] != mv2, m[0] != mv2});
            -> checked;
        end
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst0 = 1'b1; rst1 = 1'b1; rst2 = 1'b1;
        take = 1'b0; target = 32'h0;
        for (int i = 0; i < 3; i++) req_div[i] = 2;

        // R1: reset state
        tag = "R1";
        wait_ticks(4);
        cmp("R1 voted in reset", voted, 32'h0);
        cmp("R1 flags in reset", {29'd0, mism}, 32'h0);

        // R2 R3 R5 R6: release and count up in lockstep
        rst0 = 1'b0; rst1 = 1'b0; rst2 = 1'b0;
        tag = "R2 R3 R5 R6";
        wait_ticks(40);

        // R4 R9: branch to a misaligned target for one 50 MHz period
        tag = "R4 R9";
        target = 32'h0000_0203;
        take = 1'b1;
        wait_ticks(4);
        cmp("R4 branch lands aligned", voted, 32'h0000_0200);
        take = 1'b0;
        wait_ticks(8);

        // R7: copy 0 clocked at twice the rate
        tag = "R7 R5 R6";
        req_div[0] = 1;
        wait_ticks(64);
        tag = "R7";
        req_div[0] = 2;
        wait_ticks(32);
        cmp("R7 realigned flags", {29'd0, mism}, 32'h0);

        // R8: copy 2 clocked at a quarter of the rate
        tag = "R8 R5 R6";
        req_div[2] = 8;
        wait_ticks(96);
        tag = "R8";
        req_div[2] = 2;
        wait_ticks(32);
        cmp("R8 realigned flags", {29'd0, mism}, 32'h0);

        // R10: copy 1 held in reset while the others run
        tag = "R10 R1 R5";
        rst1 = 1'b1;
        wait_ticks(20);
        cmp("R10 held copy is zero", v1, 32'h0);
        tag = "R10 R2";
        rst1 = 1'b0;
        wait_ticks(32);
        cmp("R10 realigned flags", {29'd0, mism}, 32'h0);
        cmp("R10 copies agree", v1, v0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule